// File: doc/BRIEF.md
# Multi-View GPIO Output Register Bank

This block holds the output state of eight general-purpose output channels. Software sits on a simple 32-bit register bus and has three ways to change that state. A direct write replaces every bit. A masked write changes only the channels that the mask leaves open. A command write gives each channel its own two-bit action: hold, set, clear or invert. A status register reads back the state that the three writes have built up.

For each channel, a select bit decides what drives its pad. When the bit is clear, the pad follows the register-driven state. When the bit is set, the pad follows an 8-bit value presented by a processor-instruction datapath outside this block. That value never changes the stored register state. Every bus access takes one cycle. The pad outputs are registered.

Top module: `gpio_out_bank`

## Requirements
- R1: While `rst` is high at a clock edge, the output state, the select bits, `pad_out`, `bus_rdata` and `bus_ready` all become 0.
- R2: A write to offset 0x00 loads the output state from `bus_wdata[7:0]`, bit n going to channel n.
- R3: A write to offset 0x04 uses `bus_wdata[15:8]` as a mask. A channel whose mask bit is 1 keeps its value. A channel whose mask bit is 0 takes the matching bit of `bus_wdata[7:0]`.
- R4: A write to offset 0x08 applies the two-bit code in `bus_wdata[2n+1:2n]` to channel n. Code 0 holds, 1 sets to 1, 2 clears to 0, 3 inverts.
- R5: A read of offset 0x0C returns the output state in bits [7:0], with bits [31:8] reading 0. Writes to 0x0C have no effect.
- R6: Offset 0x10 is the select register. It is read/write in bits [7:0], its upper bits read 0 and ignore writes, and it resets to 0.
- R7: Reads of 0x00, 0x04, 0x08 and of any unmapped offset return 0. Writes to unmapped offsets change nothing.
- R8: An access presented with `bus_req` high at a clock edge is answered after that edge: `bus_ready` is 1 and, for a read, `bus_rdata` is valid. A write changes the state at that same edge. `bus_ready` is 0 after an edge with no request.
- R9: At each clock edge, `pad_out[n]` is loaded with `instr_val[n]` if select bit n is 1, and with state bit n otherwise. Both are taken as they stand before that edge.
- R10: `instr_val` never alters the output state read at 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completed |
| instr_val | input | 8 | Instruction-driven pad values |
| pad_out | output | 8 | Registered pad values |

## Verification
Two things can happen in the same clock edge. A bus write can change a channel's register state while that channel's pad is under instruction control and `instr_val` is changing. The bench provokes this with command and direct writes to channels whose select bit is set, with a new `instr_val` presented in the same cycle. It checks that the pad follows the instruction value and that the status readback follows only the write. Random traffic mixes all write views, select changes, reads and ignored accesses with a fresh `instr_val` on every access. Each result is compared against a bench model of state and select.

// File: rtl/gpio_out_pkg.sv
package gpio_out_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_SET  = 2'd1,
    CMD_CLR  = 2'd2,
    CMD_FLIP = 2'd3
  } chan_cmd_e;

  localparam logic [7:0] OFS_DIRECT = 8'h00;
  localparam logic [7:0] OFS_MASKED = 8'h04;
  localparam logic [7:0] OFS_CMD    = 8'h08;
  localparam logic [7:0] OFS_STATUS = 8'h0C;
  localparam logic [7:0] OFS_SELECT = 8'h10;
endpackage

// File: rtl/gpio_out_chan.sv
module gpio_out_chan
  import gpio_out_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_dir,
  input  logic       wr_msk,
  input  logic       wr_cmd,
  input  logic       dir_bit,
  input  logic       msk_bit,
  input  logic       msk_keep,
  input  logic [1:0] cmd,
  output logic       q
);
  logic nxt;

  always_comb begin
    nxt = q;
    if (wr_dir) begin
      nxt = dir_bit;
    end else if (wr_msk) begin
      nxt = msk_keep ? q : msk_bit;
    end else if (wr_cmd) begin
      case (chan_cmd_e'(cmd))
        CMD_SET:  nxt = 1'b1;
        CMD_CLR:  nxt = 1'b0;
        CMD_FLIP: nxt = ~q;
        default:  nxt = q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end

  // R2
  direct_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> q == $past(dir_bit));
  // R3
  masked_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_msk && msk_keep) |=> $stable(q));
  // R4
  cmd_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && cmd == 2'd3) |=> q != $past(q));
  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && cmd == 2'd0) |=> $stable(q));
  // R10
  no_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_dir || wr_msk || wr_cmd) |=> $stable(q));
endmodule

// File: rtl/gpio_out_busif.sv
module gpio_out_busif
  import gpio_out_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_req,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  input  logic [NCH-1:0] state,
  output logic           wr_dir,
  output logic           wr_msk,
  output logic           wr_cmd,
  output logic [NCH-1:0] sel_q,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_ready
);
  logic wr_acc, rd_acc, wr_sel;
  logic [DW-1:0] rd_mux;

  assign wr_acc = bus_req && bus_we;
  assign rd_acc = bus_req && !bus_we;
  assign wr_dir = wr_acc && (bus_addr == AW'(OFS_DIRECT));
  assign wr_msk = wr_acc && (bus_addr == AW'(OFS_MASKED));
  assign wr_cmd = wr_acc && (bus_addr == AW'(OFS_CMD));
  assign wr_sel = wr_acc && (bus_addr == AW'(OFS_SELECT));

  always_comb begin
    rd_mux = '0;
    if (bus_addr == AW'(OFS_STATUS))      rd_mux[NCH-1:0] = state;
    else if (bus_addr == AW'(OFS_SELECT)) rd_mux[NCH-1:0] = sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      bus_rdata <= '0;
      bus_ready <= 1'b0;
    end else begin
      bus_ready <= bus_req;
      bus_rdata <= rd_acc ? rd_mux : '0;
      if (wr_sel) sel_q <= bus_wdata[NCH-1:0];
    end
  end

  // R8
  ready_follow_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> bus_ready);
  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_req |=> !bus_ready);
  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_sel |=> $stable(sel_q));
  // R7
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && bus_addr != AW'(OFS_STATUS) && bus_addr != AW'(OFS_SELECT))
      |=> bus_rdata == '0);
  // R8
  one_write_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({wr_dir, wr_msk, wr_cmd, wr_sel}) <= 1);
endmodule

// File: rtl/gpio_out_padmux.sv
module gpio_out_padmux #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] sel,
  input  logic [NCH-1:0] state,
  input  logic [NCH-1:0] instr_val,
  output logic [NCH-1:0] pad_out
);
  for (genvar i = 0; i < NCH; i++) begin : g_pad
    always_ff @(posedge clk) begin
      if (rst) pad_out[i] <= 1'b0;
      else     pad_out[i] <= sel[i] ? instr_val[i] : state[i];
    end
  end

  // R9
  pad_instr_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == '1) |=> pad_out == $past(instr_val));
  // R9
  pad_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |=> pad_out == $past(state));
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank #(
  parameter int NCH = 8,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_req,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           bus_ready,
  input  logic [NCH-1:0] instr_val,
  output logic [NCH-1:0] pad_out
);
  localparam int MSK_LO = NCH;

  logic           wr_dir, wr_msk, wr_cmd;
  logic [NCH-1:0] state, sel_q;

  gpio_out_busif #(.NCH(NCH), .AW(AW), .DW(DW)) u_bus (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .state(state),
    .wr_dir(wr_dir), .wr_msk(wr_msk), .wr_cmd(wr_cmd), .sel_q(sel_q),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    gpio_out_chan u_ch (
      .clk(clk), .rst(rst),
      .wr_dir(wr_dir), .wr_msk(wr_msk), .wr_cmd(wr_cmd),
      .dir_bit(bus_wdata[i]), .msk_bit(bus_wdata[i]),
      .msk_keep(bus_wdata[MSK_LO+i]), .cmd(bus_wdata[2*i+1:2*i]),
      .q(state[i])
    );
  end

  gpio_out_padmux #(.NCH(NCH)) u_pad (
    .clk(clk), .rst(rst), .sel(sel_q), .state(state),
    .instr_val(instr_val), .pad_out(pad_out)
  );
endmodule

// File: tb/gpio_out_bank_tb.sv
module gpio_out_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic [7:0]  instr_val = '0;
  logic [7:0]  pad_out;

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] m_state = '0, m_sel = '0;

  always #5 clk = ~clk;

  gpio_out_bank u_dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .instr_val(instr_val), .pad_out(pad_out)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog R8: act=%0d exp<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: act=%h exp=%h", rq, act, exp);
    end
  endtask

  function automatic logic [7:0] f_mask(input logic [7:0] s, input logic [31:0] w);
    return (s & w[15:8]) | (w[7:0] & ~w[15:8]);
  endfunction

  function automatic logic [7:0] f_cmd(input logic [7:0] s, input logic [31:0] w);
    logic [7:0] r = s;
    for (int n = 0; n < 8; n++) begin
      case (w[2*n+:2])
        2'd1: r[n] = 1'b1;
        2'd2: r[n] = 1'b0;
        2'd3: r[n] = ~s[n];
        default: r[n] = s[n];
      endcase
    end
    return r;
  endfunction

  task automatic acc(input bit we, input logic [7:0] a, input logic [31:0] wd,
                     input logic [7:0] iv, output logic [31:0] rd);
    logic [7:0] exp_pad;
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd; instr_val = iv;
    exp_pad = (m_sel & iv) | (~m_sel & m_state);
    @(posedge clk); #1;
    bus_req = 1'b0;
    rd = bus_rdata;
    chk("R8 ready", {31'd0, bus_ready}, 32'd1);
    chk("R9 pad", {24'd0, pad_out}, {24'd0, exp_pad});
    if (we) begin
      case (a)
        8'h00: m_state = wd[7:0];
        8'h04: m_state = f_mask(m_state, wd);
        8'h08: m_state = f_cmd(m_state, wd);
        8'h10: m_sel = wd[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] wd, input logic [7:0] iv);
    logic [31:0] d;
    acc(1'b1, a, wd, iv, d);
  endtask

  task automatic rd_chk(input string rq, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    acc(1'b0, a, 32'd0, instr_val, d);
    chk(rq, d, exp);
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1357_9bdf));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 pad", {24'd0, pad_out}, 32'd0);
    chk("R1 ready", {31'd0, bus_ready}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    @(negedge clk); rst = 1'b0;
    rd_chk("R1 state", 8'h0C, 32'd0);
    rd_chk("R1 R6 sel", 8'h10, 32'd0);
    // R8 idle
    @(posedge clk); #1;
    chk("R8 idle ready", {31'd0, bus_ready}, 32'd0);
    // R2
    wr(8'h00, 32'hFFFF_FFA5, 8'h00);
    rd_chk("R2 R5 direct", 8'h0C, 32'h0000_00A5);
    // R3
    wr(8'h04, 32'h0000_F00F, 8'h00);
    rd_chk("R3 masked", 8'h0C, 32'h0000_00AF);
    // R4 invert all, then hold all, then mixed
    wr(8'h08, 32'h0000_FFFF, 8'h00);
    rd_chk("R4 invert", 8'h0C, 32'h0000_0050);
    wr(8'h08, 32'hFFFF_0000, 8'h00);
    rd_chk("R4 hold", 8'h0C, 32'h0000_0050);
    wr(8'h08, 32'h0000_9E46, 8'h00);
    rd_chk("R4 mixed", 8'h0C, {24'd0, m_state});
    // R5 write to status ignored
    wr(8'h0C, 32'h0000_00FF, 8'h00);
    rd_chk("R5 status wr ignored", 8'h0C, {24'd0, m_state});
    // R6 upper bits ignored
    wr(8'h10, 32'hFFFF_FF0F, 8'h00);
    rd_chk("R6 sel", 8'h10, 32'h0000_000F);
    // R7 write-only and unmapped reads
    rd_chk("R7 rd 00", 8'h00, 32'd0);
    rd_chk("R7 rd 04", 8'h04, 32'd0);
    rd_chk("R7 rd 08", 8'h08, 32'd0);
    rd_chk("R7 rd 20", 8'h20, 32'd0);
    wr(8'h24, 32'hFFFF_FFFF, 8'hFF);
    rd_chk("R7 unmapped wr", 8'h0C, {24'd0, m_state});
    // R10 concurrent: channel 0 under instruction control, command write and instr change same cycle
    wr(8'h10, 32'h0000_0001, 8'h00);
    for (int k = 0; k < 6; k++) begin
      wr(8'h08, 32'h0000_0003, k[0] ? 8'h01 : 8'h00);
      rd_chk("R10 state follows command", 8'h0C, {24'd0, m_state});
    end
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 7);
      logic [31:0] w = $urandom;
      logic [7:0] iv = 8'($urandom);
      case (op)
        0: wr(8'h00, w, iv);
        1: wr(8'h04, w, iv);
        2: wr(8'h08, w, iv);
        3: wr(8'h10, w, iv);
        4: begin acc(1'b0, 8'h0C, 32'd0, iv, d); chk("R5 R10 rand status", d, {24'd0, m_state}); end
        5: begin acc(1'b0, 8'h10, 32'd0, iv, d); chk("R6 rand sel", d, {24'd0, m_sel}); end
        6: begin acc(1'b0, 8'($urandom_range(0, 2) * 4), 32'd0, iv, d); chk("R7 rand wo", d, 32'd0); end
        default: wr(8'h0C, w, iv);
      endcase
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule